// File: doc/BRIEF.md
# Register-Mapped GPIO Port

This block is a general-purpose I/O port whose line count equals its register width (8, 16, 32 or 64). Software reaches it over a plain synchronous register bus that has an address, a write strobe, a read strobe and separate write and read data. The block keeps an output latch and a per-line direction mask. It drives the pad-side value and output-enable vectors from them, and it samples the pad inputs through a two-stage synchroniser.

The port has five register windows. A value window loads the latch in one write. A raise window and a lower window change only the lines whose written bit is 1. Two direction windows hold complementary copies of one direction mask. A build option removes the lower window, and the raise window then becomes a full value register. A second option makes the port input-only. Two more options change how bus bits map to lines: the bit order can be reversed, and the byte order can be swapped.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: After reset every line is an input (`pad_oe` all 0), `pad_out` is all 0 and `bus_rdata` is 0.
- R2: A write to address 0 (value) loads the output latch with the written word, and `pad_out` shows it from the next cycle. Without a write, `pad_out` and `pad_oe` hold.
- R3: A write to address 1 (raise) sets every latch bit whose written bit is 1 and leaves the others unchanged.
- R4: A write to address 2 (lower) clears every latch bit whose written bit is 1 and leaves the others unchanged.
- R5: A write to address 3 (output mask) sets the direction so that a 1 bit makes its line an output, visible on `pad_oe` the next cycle.
- R6: A write to address 4 (input mask) makes a line an input where its bit is 1. Reads of address 3 and address 4 always return bitwise complements.
- R7: A read of address 0 returns the latch bit for output lines and the synchronised pad level for input lines. A pad change reaches this read path two clock edges after it is applied.
- R8: A read of address 1 returns the output latch. Reads of address 2 and of addresses 5 to 7 return 0.
- R9: With MIRROR set, line n corresponds to bus bit WIDTH-1-n in every register, for both reads and writes.
- R10: With BYTE_SWAP set, bus byte k corresponds to line byte WIDTH/8-1-k, with bit order kept inside each byte. A 64-bit build with this option, or a width other than 8, 16, 32 or 64, stops elaboration.
- R11: With HAS_CLR clear, a write to address 1 loads the whole latch (0 drives low), a read of it returns the latch, and a write to address 2 has no effect.
- R12: With NO_OUTPUT set, writes to addresses 0 to 4 are ignored, `pad_oe` and `pad_out` stay all 0, and address 4 reads all ones.
- R13: `bus_rdata` is updated at the clock edge that samples `bus_rd` and holds otherwise. A read and a write in the same cycle return the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register window select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | WIDTH | Write data in bus bit order |
| bus_rdata | output | WIDTH | Registered read data in bus bit order |
| pad_in | input | WIDTH | Asynchronous pad input levels |
| pad_out | output | WIDTH | Output latch driven to the pads |
| pad_oe | output | WIDTH | Per-line output enable, 1 = output |

## Verification
A corrupted latch bit shows on `pad_out` in the cycle after the write that caused it, and on a value or raise readback one cycle after the read strobe. A direction bit that is wrong shows at once on `pad_oe`. It also shows in the mixing of pad and latch on a value read. If the two direction windows lose their complement relation, reading both windows back exposes it. Mapping faults in the mirrored or byte-swapped variants make the pad vectors disagree with the written pattern on the first write.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

    localparam int unsigned ADDR_W = 3;

    // Register window selects; the bus address decodes against these.
    typedef enum logic [ADDR_W-1:0] {
        SEL_VALUE   = 3'd0,
        SEL_RAISE   = 3'd1,
        SEL_LOWER   = 3'd2,
        SEL_DIR_OUT = 3'd3,
        SEL_DIR_IN  = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d        = sy_q;
        sy_d.stage1 = async_in;
        sy_d.stage2 = sy_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign sync_out = sy_q.stage2;

    // R7: the read path sees the pad value from two edges earlier
    p_two_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |=> sync_out == $past(async_in, 2));

endmodule

// File: rtl/gpio_lane_map.sv
// Permutes between bus bit order and line order. Bit reversal and byte
// reversal are both involutions and commute, so one instance serves each way.
module gpio_lane_map #(
    parameter int unsigned WIDTH     = 32,
    parameter bit          MIRROR    = 1'b0,
    parameter bit          BYTE_SWAP = 1'b0
) (
    input  logic [WIDTH-1:0] in_vec,
    output logic [WIDTH-1:0] out_vec
);

    localparam int NBYTES = WIDTH / 8;

    for (genvar n = 0; n < WIDTH; n++) begin : g_lane
        localparam int MIR_IDX = MIRROR ? (WIDTH - 1 - n) : n;
        localparam int SRC_IDX = BYTE_SWAP
            ? ((NBYTES - 1 - MIR_IDX / 8) * 8 + (MIR_IDX % 8))
            : MIR_IDX;
        assign out_vec[n] = in_vec[SRC_IDX];
    end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_mmio_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [ADDR_W-1:0] sel,
    input  logic [WIDTH-1:0]  latch,
    input  logic [WIDTH-1:0]  dir,
    input  logic [WIDTH-1:0]  pad_sync,
    output logic [WIDTH-1:0]  rd_line
);

    always_comb begin
        unique case (reg_sel_e'(sel))
            SEL_VALUE:   rd_line = (dir & latch) | (~dir & pad_sync);
            SEL_RAISE:   rd_line = latch;
            SEL_DIR_OUT: rd_line = dir;
            SEL_DIR_IN:  rd_line = ~dir;
            default:     rd_line = '0;
        endcase
    end

endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl
    import gpio_mmio_pkg::*;
#(
    parameter int unsigned WIDTH     = 32,
    parameter bit          MIRROR    = 1'b0,
    parameter bit          BYTE_SWAP = 1'b0,
    parameter bit          HAS_CLR   = 1'b1,
    parameter bit          NO_OUTPUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);

    // R10: reject unsupported build combinations at elaboration
    if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
        $error("gpio_mmio_ctrl: WIDTH must be 8, 16, 32 or 64");
    end
    if (BYTE_SWAP && WIDTH == 64) begin : g_bad_swap
        $error("gpio_mmio_ctrl: byte swap is not available at 64 bits");
    end

    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic [WIDTH-1:0] wr_line;
    logic [WIDTH-1:0] rd_line;
    logic [WIDTH-1:0] rd_bus;
    logic [WIDTH-1:0] pad_sync;

    gpio_lane_map #(.WIDTH(WIDTH), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_wmap (
        .in_vec  (bus_wdata),
        .out_vec (wr_line)
    );

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    gpio_read_mux #(.WIDTH(WIDTH)) u_rmux (
        .sel      (bus_addr),
        .latch    (st_q.latch),
        .dir      (st_q.dir),
        .pad_sync (pad_sync),
        .rd_line  (rd_line)
    );

    gpio_lane_map #(.WIDTH(WIDTH), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_rmap (
        .in_vec  (rd_line),
        .out_vec (rd_bus)
    );

    always_comb begin
        st_d = st_q;
        if (bus_rd) begin
            st_d.rdata = rd_bus;
        end
        if (bus_wr && !NO_OUTPUT) begin
            unique case (reg_sel_e'(bus_addr))
                SEL_VALUE:   st_d.latch = wr_line;
                SEL_RAISE:   st_d.latch = HAS_CLR ? (st_q.latch | wr_line) : wr_line;
                SEL_LOWER:   if (HAS_CLR) st_d.latch = st_q.latch & ~wr_line;
                SEL_DIR_OUT: st_d.dir = wr_line;
                SEL_DIR_IN:  st_d.dir = ~wr_line;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign pad_out   = st_q.latch;
    assign pad_oe    = st_q.dir;

    // R2: pad vectors hold while no write occurs
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pad_out) && $stable(pad_oe)));

    // R13: read data holds without a read strobe
    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    if (NO_OUTPUT) begin : g_chk_noout
        // R12: an input-only build never drives
        p_never_drive_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_oe == '0) && (pad_out == '0));
    end else begin : g_chk_out
        // R5: output enable follows the output-mask write
        p_oe_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == SEL_DIR_OUT) |=> pad_oe == $past(wr_line));
        // R6: input-mask write gives the complement
        p_oe_invert_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == SEL_DIR_IN) |=> pad_oe == ~$past(wr_line));
        if (HAS_CLR) begin : g_chk_clr
            // R3: raise never lowers a line
            p_raise_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == SEL_RAISE) |=> ((~pad_out & $past(pad_out)) == '0));
            // R4: lower never raises a line
            p_lower_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == SEL_LOWER) |=> ((pad_out & ~$past(pad_out)) == '0));
        end else begin : g_chk_noclr
            // R11: the lower window has no effect
            p_lower_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == SEL_LOWER) |=> $stable(pad_out));
        end
    end

endmodule

// File: tb/gpio_mmio_ctrl_bench.sv
module gpio_mmio_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    // dut ids for the scoreboard
    localparam int D_MAIN = 0;
    localparam int D_MIR  = 1;
    localparam int D_SWP  = 2;
    localparam int D_NCL  = 3;
    localparam int D_NOO  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;

    logic [31:0] pin_main = 32'hA5A5_0000;
    logic [15:0] pin_16   = '0;
    logic [7:0]  pin_8    = '0;

    logic [31:0] rd_main, po_main, oe_main;
    logic [15:0] rd_mir, po_mir, oe_mir;
    logic [15:0] rd_swp, po_swp, oe_swp;
    logic [7:0]  rd_ncl, po_ncl, oe_ncl;
    logic [7:0]  rd_noo, po_noo, oe_noo;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mmio_ctrl #(.WIDTH(32)) u_gpio_mmio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rd_main), .pad_in(pin_main),
        .pad_out(po_main), .pad_oe(oe_main));

    gpio_mmio_ctrl #(.WIDTH(16), .MIRROR(1'b1)) u_gpio_mmio_ctrl_mir (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata[15:0]), .bus_rdata(rd_mir), .pad_in(pin_16),
        .pad_out(po_mir), .pad_oe(oe_mir));

    gpio_mmio_ctrl #(.WIDTH(16), .BYTE_SWAP(1'b1)) u_gpio_mmio_ctrl_swp (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata[15:0]), .bus_rdata(rd_swp), .pad_in(pin_16),
        .pad_out(po_swp), .pad_oe(oe_swp));

    gpio_mmio_ctrl #(.WIDTH(8), .HAS_CLR(1'b0)) u_gpio_mmio_ctrl_ncl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata[7:0]), .bus_rdata(rd_ncl), .pad_in(pin_8),
        .pad_out(po_ncl), .pad_oe(oe_ncl));

    gpio_mmio_ctrl #(.WIDTH(8), .NO_OUTPUT(1'b1)) u_gpio_mmio_ctrl_noo (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata[7:0]), .bus_rdata(rd_noo), .pad_in(pin_8),
        .pad_out(po_noo), .pad_oe(oe_noo));

    typedef struct {
        int          dut;
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t sb_q[$];

    int drv_checks = 0, drv_fails = 0;
    int mon_checks = 0, mon_fails = 0;
    int wd_fails = 0;
    logic rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= bus_rd;

    function automatic logic [31:0] pick_rdata(int dut);
        case (dut)
            D_MAIN:  return rd_main;
            D_MIR:   return {16'h0, rd_mir};
            D_SWP:   return {16'h0, rd_swp};
            D_NCL:   return {24'h0, rd_ncl};
            default: return {24'h0, rd_noo};
        endcase
    endfunction

    // monitor: compare each read result one edge after its strobe
    always @(negedge clk) begin
        if (rd_seen) begin
            sb_item_t it;
            logic [31:0] act;
            if (sb_q.size() == 0) begin
                mon_fails++;
                $display("FAIL scoreboard: read result with no expected item");
            end else begin
                it  = sb_q.pop_front();
                act = pick_rdata(it.dut);
                mon_checks++;
                if (act !== it.exp) begin
                    mon_fails++;
                    $display("FAIL %s: dut %0d read got %h expected %h", it.req, it.dut, act, it.exp);
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        drv_checks++;
        if (act !== exp) begin
            drv_fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic do_read(input int dut, input logic [2:0] a, input logic [31:0] exp, input string req);
        sb_item_t it;
        it.dut = dut; it.exp = exp; it.req = req;
        sb_q.push_back(it);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic do_read_write(input logic [2:0] a, input logic [31:0] d, input logic [31:0] exp, input string req);
        sb_item_t it;
        it.dut = D_MAIN; it.exp = exp; it.req = req;
        sb_q.push_back(it);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        bus_rd    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        wd_fails = 1;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed",
                 drv_checks + mon_checks + 1, drv_fails + mon_fails + wd_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 oe", oe_main, 32'h0);
        check("R1 out", po_main, 32'h0);
        check("R1 rdata", rd_main, 32'h0);
        check("R1 noout oe", {24'h0, oe_noo}, 32'h0);
        do_read(D_MAIN, 3'd3, 32'h0, "R1 dirout read");
        do_read(D_MAIN, 3'd4, 32'hFFFF_FFFF, "R6 dirin reset");

        // R5/R9/R10: output mask write, mapped per variant
        do_write(3'd3, 32'h0000_000F);
        check("R5 oe", oe_main, 32'h0000_000F);
        check("R9 mirrored oe", {16'h0, oe_mir}, 32'h0000_F000);
        check("R10 swapped oe", {16'h0, oe_swp}, 32'h0000_0F00);
        check("R12 noout oe", {24'h0, oe_noo}, 32'h0);

        // R2: value write
        do_write(3'd0, 32'h1234_5678);
        check("R2 out", po_main, 32'h1234_5678);
        check("R9 mirrored out", {16'h0, po_mir}, 32'h0000_1E6A);
        check("R10 swapped out", {16'h0, po_swp}, 32'h0000_7856);
        check("R2 noclr out", {24'h0, po_ncl}, 32'h0000_0078);
        check("R12 noout out", {24'h0, po_noo}, 32'h0);

        // R3/R11: raise window
        do_write(3'd1, 32'h0000_8001);
        check("R3 out", po_main, 32'h1234_D679);
        check("R9 mirrored raise", {16'h0, po_mir}, 32'h0000_9E6B);
        check("R10 swapped raise", {16'h0, po_swp}, 32'h0000_79D6);
        check("R11 full value", {24'h0, po_ncl}, 32'h0000_0001);

        // R4/R11: lower window
        do_write(3'd2, 32'h0000_0070);
        check("R4 out", po_main, 32'h1234_D609);
        check("R9 mirrored lower", {16'h0, po_mir}, 32'h0000_906B);
        check("R10 swapped lower", {16'h0, po_swp}, 32'h0000_09D6);
        check("R11 lower ignored", {24'h0, po_ncl}, 32'h0000_0001);

        // R8/R11/R9/R10: readback paths
        do_read(D_MAIN, 3'd1, 32'h1234_D609, "R8 raise read");
        do_read(D_MAIN, 3'd2, 32'h0, "R8 lower read");
        do_read(D_MAIN, 3'd7, 32'h0, "R8 unmapped read");
        do_read(D_NCL, 3'd1, 32'h0000_0001, "R11 value read");
        do_read(D_MIR, 3'd0, 32'h0000_0009, "R9 mirrored value read");
        do_read(D_SWP, 3'd0, 32'h0000_0009, "R10 swapped value read");

        // R7: mix of latch and pad, then pad latency
        do_read(D_MAIN, 3'd0, 32'hA5A5_0009, "R7 mixed read");
        pin_main = 32'h0000_FF00;
        do_read(D_MAIN, 3'd0, 32'hA5A5_0009, "R7 first edge old");
        do_read(D_MAIN, 3'd0, 32'hA5A5_0009, "R7 second edge old");
        do_read(D_MAIN, 3'd0, 32'h0000_FF09, "R7 synced new");

        // R6/R12: input mask write keeps both windows complementary
        do_write(3'd4, 32'hFFFF_FF00);
        check("R6 oe", oe_main, 32'h0000_00FF);
        do_read(D_MAIN, 3'd3, 32'h0000_00FF, "R6 dirout read");
        do_read(D_MAIN, 3'd4, 32'hFFFF_FF00, "R6 dirin read");
        do_read(D_NOO, 3'd3, 32'h0, "R12 dirout read");
        do_read(D_NOO, 3'd4, 32'h0000_00FF, "R12 dirin read");

        // R13: read and write together return the old state
        do_read_write(3'd0, 32'h0, 32'h0000_FF09, "R13 read before write");
        check("R13 write applied", po_main, 32'h0);
        do_read(D_MAIN, 3'd0, 32'h0000_FF00, "R13 read after write");
        check("R13 rdata hold", rd_main, 32'h0000_FF00);
        check("R12 noout final", {16'h0, oe_noo, po_noo}, 32'h0);

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed",
                 drv_checks + mon_checks, drv_fails + mon_fails);
        $finish;
    end

endmodule